// File: doc/BRIEF.md
# Watchdog Timer with Reset Pulse

This block is a watchdog peripheral. It contains an up-counter and a compare register. When the counter steps onto the compare value, a match event occurs. Each match event can set a status flag and raise an interrupt, clear and halt the counter, ask for a one-cycle internal reset, start an active-low external reset pulse and update a match output pin. Software can request either reset at once, without waiting for a match. A status bit records that the block has issued a reset. Only a power-on reset clears that bit, so it survives the system reset the watchdog itself causes.

Software reaches the block over a plain register bus: `bus_wr` writes `bus_wdata` to the word at index `bus_addr`, and `bus_rdata` shows the word at index `bus_addr` in the same cycle. Reads have no side effects. The bus carries no data stream, so the block has no valid/ready handshake and no back-pressure. Every pin is a plain level signal. The counter runs on `clk`, and the external pulse length is counted in `clk` cycles. `dbg_halt` lets a debugger freeze the count.

Word indices and their registers:

| Index | Register | Contents |
|-------|----------|----------|
| 0 | flag | bit0 match flag; write 1 to clear |
| 1 | run control | bit0 run; bit1 clear (write-only); bit2 halt-on-debug |
| 2 | count | read-only |
| 3 | action | bit0 irq enable, bit2 stop, bit3 internal reset, bit4 external reset; bit5 and bit6 are write-only force strobes |
| 4 | compare | compare value |
| 5 | pin control | bit0 pin state, bits5:4 match action |
| 6 | pulse width | pulse length |
| 7 | cause | bit0 sticky cause bit (read-only) |

Top module: `wdog_timer`

## Requirements
- R1: When `rst_n` and `por_n` are released, these all read 0: the count, the flag, the compare value and the cause bit. At the same point `irq`, `int_rst_req` and `match_out` are 0 and `rst_out_n` is 1.
- R2: While run is set, the count rises by one on each clock. It holds while both halt-on-debug and `dbg_halt` are set. `dbg_halt` has no effect when halt-on-debug is clear.
- R3: A write to run control with bit1 set clears the count to 0 and clears run. The count then stays at 0. Writes to index 2 are ignored.
- R4: The match flag is set on the clock edge where the count steps onto the compare value. If run is set at edge e0, the flag is seen after edge e0+M for compare value M. Writing 1 to bit0 of index 0 clears the flag. The flag is set again only by a new step onto the compare value.
- R5: `irq` is high exactly when the match flag is set and bit0 of index 3 is set.
- R6: When bit2 of index 3 is set, a match event clears the count to 0 and clears run.
- R7: When bit3 of index 3 is set, a match event raises `int_rst_req` for exactly one cycle, starting at the match edge. A write with bit5 set raises it for one cycle at the write edge.
- R8: Take a pulse width L in the range 1 to 65535. A match event with bit4 of index 3 set drives `rst_out_n` low for exactly L cycles, starting at the match edge. A write with bit6 set does the same at the write edge. With L equal to 0, no pulse is produced.
- R9: At a match event, action value 1 in bits5:4 of index 5 drives `match_out` to 0, value 2 drives it to 1, value 3 toggles it and value 0 leaves it as it is. Writing bit0 of index 5 sets `match_out` directly.
- R10: The cause bit (bit0 of index 7) is set when the block issues an internal reset or an external pulse of nonzero length. `rst_n` does not clear it. Only `por_n` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock, also the counting clock |
| rst_n | input | 1 | asynchronous active-low system reset |
| por_n | input | 1 | asynchronous active-low power-on reset |
| dbg_halt | input | 1 | debugger halt request |
| bus_wr | input | 1 | register write strobe |
| bus_addr | input | 3 | register word index |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr` |
| irq | output | 1 | match interrupt |
| match_out | output | 1 | match output pin |
| int_rst_req | output | 1 | one-cycle internal reset request |
| rst_out_n | output | 1 | active-low external reset pulse |

## Verification
The compare value is swept from 1 to 8 with stop-on-match. This shows whether the flag rises on the exact edge where the count reaches the value, rather than one cycle early or late. The pulse width is swept from 1 to 6 by force, and 3 is also used through a match. Each low period is counted, which separates an exact-length pulse from an off-by-one one. Width 0 shows that no pulse is produced. Other patterns check the debug halt with halt-on-debug set and with it clear, each pin action in turn, and the cause bit across a system reset and then across a power-on reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IX_FLAG  = 3'd0,
    IX_RUN   = 3'd1,
    IX_COUNT = 3'd2,
    IX_ACT   = 3'd3,
    IX_CMP   = 3'd4,
    IX_PIN   = 3'd5,
    IX_WIDTH = 3'd6,
    IX_CAUSE = 3'd7
  } reg_idx_e;

  // bit positions inside the action register
  localparam int ACT_IRQ   = 0;
  localparam int ACT_STOP  = 2;
  localparam int ACT_IRST  = 3;
  localparam int ACT_XRST  = 4;
  localparam int ACT_FIRST = 5;
  localparam int ACT_FXRST = 6;

  typedef struct packed {
    logic irq_en;
    logic stop;
    logic int_on;
    logic ext_on;
  } act_cfg_t;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             stop_on_hit,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = count + ONE;
    hit = tick && !clear && (nxt == cmp_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clear)            count <= '0;
    else if (hit && stop_on_hit) count <= '0;
    else if (tick)             count <= nxt;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             pulse_n
);
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= len;
    else if (left_q != '0)   left_q <= left_q - {{(LEN_W-1){1'b0}}, 1'b1};
  end

  assign pulse_n = (left_q == '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int WIDTH_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              dbg_halt,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              match_out,
  output logic              int_rst_req,
  output logic              rst_out_n
);
  reg_idx_e idx;
  assign idx = reg_idx_e'(bus_addr);

  logic wr_flag, wr_run, wr_act, wr_cmp, wr_pin, wr_width;
  always_comb begin
    wr_flag  = bus_wr && (idx == IX_FLAG);
    wr_run   = bus_wr && (idx == IX_RUN);
    wr_act   = bus_wr && (idx == IX_ACT);
    wr_cmp   = bus_wr && (idx == IX_CMP);
    wr_pin   = bus_wr && (idx == IX_PIN);
    wr_width = bus_wr && (idx == IX_WIDTH);
  end

  logic               run_q, dbg_en_q, flag_q, pin_q, cause_q, irst_q;
  act_cfg_t           act_q;
  pin_act_e           pin_act_q;
  logic [DATA_W-1:0]  cmp_q;
  logic [WIDTH_W-1:0] width_q;
  logic [DATA_W-1:0]  count;
  logic               hit, tick, clr, int_trig, ext_trig;

  assign tick = run_q && !(dbg_en_q && dbg_halt);
  assign clr  = wr_run && bus_wdata[1];

  wdog_counter #(.CNT_W(DATA_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .clear      (clr),
    .stop_on_hit(act_q.stop),
    .cmp_val    (cmp_q),
    .count      (count),
    .hit        (hit)
  );

  assign int_trig = (hit && act_q.int_on) || (wr_act && bus_wdata[ACT_FIRST]);
  assign ext_trig = (hit && act_q.ext_on) || (wr_act && bus_wdata[ACT_FXRST]);

  wdog_pulse #(.LEN_W(WIDTH_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ext_trig),
    .len    (width_q),
    .pulse_n(rst_out_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      dbg_en_q  <= 1'b0;
      flag_q    <= 1'b0;
      irst_q    <= 1'b0;
      act_q     <= '0;
      pin_q     <= 1'b0;
      pin_act_q <= PIN_KEEP;
      cmp_q     <= '0;
      width_q   <= '0;
    end else begin
      irst_q <= int_trig;

      if (wr_run) begin
        run_q    <= bus_wdata[0] && !bus_wdata[1];
        dbg_en_q <= bus_wdata[2];
      end else if (hit && act_q.stop) begin
        run_q <= 1'b0;
      end

      if (hit)                         flag_q <= 1'b1;
      else if (wr_flag && bus_wdata[0]) flag_q <= 1'b0;

      if (wr_act) begin
        act_q.irq_en <= bus_wdata[ACT_IRQ];
        act_q.stop   <= bus_wdata[ACT_STOP];
        act_q.int_on <= bus_wdata[ACT_IRST];
        act_q.ext_on <= bus_wdata[ACT_XRST];
      end

      if (wr_pin) begin
        pin_q     <= bus_wdata[0];
        pin_act_q <= pin_act_e'(bus_wdata[5:4]);
      end else if (hit) begin
        case (pin_act_q)
          PIN_LOW:  pin_q <= 1'b0;
          PIN_HIGH: pin_q <= 1'b1;
          PIN_FLIP: pin_q <= !pin_q;
          default:  pin_q <= pin_q;
        endcase
      end

      if (wr_cmp)   cmp_q   <= bus_wdata;
      if (wr_width) width_q <= bus_wdata[WIDTH_W-1:0];
    end
  end

  // cleared by power-on only: it must outlive the reset it reports
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_q <= 1'b0;
    else if (int_trig || (ext_trig && (width_q != '0))) cause_q <= 1'b1;
  end

  assign irq         = flag_q && act_q.irq_en;
  assign match_out   = pin_q;
  assign int_rst_req = irst_q;

  always_comb begin
    case (idx)
      IX_FLAG:  bus_rdata = DATA_W'(flag_q);
      IX_RUN:   bus_rdata = DATA_W'({dbg_en_q, 1'b0, run_q});
      IX_COUNT: bus_rdata = count;
      IX_ACT:   bus_rdata = DATA_W'({act_q.ext_on, act_q.int_on, act_q.stop, 1'b0, act_q.irq_en});
      IX_CMP:   bus_rdata = cmp_q;
      IX_PIN:   bus_rdata = DATA_W'({pin_act_q, 3'b000, pin_q});
      IX_WIDTH: bus_rdata = DATA_W'(width_q);
      default:  bus_rdata = DATA_W'(cause_q);
    endcase
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             dbg_en,
  input logic             dbg_halt,
  input logic             run_wr,
  input logic [CNT_W-1:0] count,
  input logic             tick,
  input logic             flag,
  input logic             ext_trig,
  input logic             rst_out_n,
  input logic             cause
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (dbg_en && dbg_halt && !run_wr) |=> $stable(count)); // R2

  AST_FLAG_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(flag) |-> $past(tick)); // R4

  AST_PULSE_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $fell(rst_out_n) |-> $past(ext_trig)); // R8

  AST_PULSE_MARKS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !rst_out_n |-> cause); // R10

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    cause |=> cause); // R10
endmodule

bind wdog_timer wdog_chk #(.CNT_W(wdog_pkg::DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .por_n    (por_n),
  .dbg_en   (dbg_en_q),
  .dbg_halt (dbg_halt),
  .run_wr   (wr_run),
  .count    (count),
  .tick     (tick),
  .flag     (flag_q),
  .ext_trig (ext_trig),
  .rst_out_n(rst_out_n),
  .cause    (cause_q)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, dbg_halt = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, match_out, int_rst_req, rst_out_n;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .dbg_halt(dbg_halt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .match_out(match_out),
    .int_rst_req(int_rst_req), .rst_out_n(rst_out_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // called in the low phase; spans one rising edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v, a;
    step(3);
    rst_n = 1'b1; por_n = 1'b1;
    step(1);

    // R1 reset state
    rd(2, v); chk("R1 count", v, 0);
    rd(0, v); chk("R1 flag", v, 0);
    rd(4, v); chk("R1 compare", v, 0);
    rd(7, v); chk("R1 cause", v, 0);
    chk("R1 pins", {irq, int_rst_req, match_out, rst_out_n}, 4'b0001);

    // R8/R10 zero width: no pulse, no cause
    wr(6, 0); wr(3, 1 << 6);
    chk("R8 zero width", rst_out_n, 1); step(2);
    chk("R8 zero width later", rst_out_n, 1);
    rd(7, v); chk("R10 zero width no cause", v, 0);

    // R4 R6 R5 compare sweep with stop
    for (int m = 1; m <= 8; m++) begin
      wr(1, 2); wr(0, 1); wr(4, m); wr(3, 1 << 2); wr(1, 1);
      step(m - 1);
      rd(0, v); chk("R4 flag before hit", v, 0);
      rd(2, v); chk("R2 count before hit", v, m - 1);
      step(1);
      rd(0, v); chk("R4 flag at hit", v, 1);
      chk("R5 irq masked", irq, 0);
      rd(2, v); chk("R6 count cleared", v, 0);
      step(2);
      rd(2, v); chk("R6 stays stopped", v, 0);
    end

    // R4 R5 no stop, W1C, once per event
    wr(1, 2); wr(0, 1); wr(4, 5); wr(3, 1); wr(1, 1);
    step(5);
    rd(0, v); chk("R4 flag", v, 1);
    chk("R5 irq", irq, 1);
    rd(2, v); chk("R4 count passes", v, 5);
    step(3); wr(0, 1);
    rd(0, v); chk("R4 cleared", v, 0);
    chk("R5 irq cleared", irq, 0);
    rd(2, v); chk("R2 count", v, 9);
    step(4);
    rd(0, v); chk("R4 no refire", v, 0);

    // R2 debug halt
    wr(1, 2); wr(3, 0); wr(4, 1000); wr(1, 5);
    dbg_halt = 1'b1;
    step(5);
    rd(2, v); chk("R2 halted", v, 0);
    dbg_halt = 1'b0; step(3);
    rd(2, v); chk("R2 resumed", v, 3);
    dbg_halt = 1'b1; wr(1, 1);
    step(4);
    rd(2, v); chk("R2 halt ignored", v, 7);
    // R3 count write ignored, clear
    rd(2, a); wr(2, 32'h55);
    rd(2, v); chk("R3 write ignored", v, a + 1);
    dbg_halt = 1'b0;
    wr(1, 3);
    rd(2, v); chk("R3 cleared", v, 0);
    step(3);
    rd(2, v); chk("R3 stays cleared", v, 0);

    // R9 pin actions
    wr(4, 2); wr(3, 1 << 2); wr(5, 32'h20); wr(1, 1);
    step(1); chk("R9 before hit", match_out, 0);
    step(1); chk("R9 high", match_out, 1);
    wr(5, 32'h11); chk("R9 direct write", match_out, 1);
    wr(1, 1); step(2); chk("R9 low", match_out, 0);
    wr(5, 32'h30); wr(1, 1); step(2); chk("R9 toggle up", match_out, 1);
    wr(1, 1); step(2); chk("R9 toggle down", match_out, 0);
    wr(5, 32'h01); wr(1, 1); step(2); chk("R9 keep", match_out, 1);

    // R8 width sweep by force
    wr(3, 0);
    for (int l = 1; l <= 6; l++) begin
      int n;
      wr(6, l); wr(3, 1 << 6);
      n = 0;
      while (!rst_out_n && n < 100) begin n++; step(1); end
      chk("R8 forced width", n, l);
    end
    rd(7, v); chk("R10 cause set", v, 1);

    // R8 pulse on match
    wr(1, 2); wr(6, 3); wr(4, 4); wr(3, (1 << 4) | (1 << 2)); wr(1, 1);
    step(3); chk("R8 before hit", rst_out_n, 1);
    step(1);
    begin
      int n = 0;
      while (!rst_out_n && n < 100) begin n++; step(1); end
      chk("R8 match width", n, 3);
    end

    // R7 internal reset request
    wr(1, 2); wr(4, 3); wr(3, (1 << 3) | (1 << 2)); wr(1, 1);
    step(2); chk("R7 before hit", int_rst_req, 0);
    step(1); chk("R7 at hit", int_rst_req, 1);
    step(1); chk("R7 one cycle", int_rst_req, 0);
    wr(3, 1 << 5); chk("R7 force", int_rst_req, 1);
    step(1); chk("R7 force one cycle", int_rst_req, 0);

    // R10 sticky across system reset, cleared by power-on
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    rd(7, v); chk("R10 survives rst_n", v, 1);
    rd(4, v); chk("R1 compare after rst_n", v, 0);
    por_n = 1'b0; step(2); por_n = 1'b1; step(1);
    rd(7, v); chk("R10 cleared by por_n", v, 0);

    finish_up();
  end
endmodule